// File: doc/BRIEF.md
# LCD Panel Strobe Timing Generator

This block produces the control strobes that a 240x320 TFT panel with a 16-bit pixel port needs, all counted in pixel-clock cycles. There are five strobes. A polarity reversal signal flips every line. A one-clock line latch pulse marks each line. A frame start pulse is two lines wide. A one-clock line start pulse opens each line. An active-low enable window spans the active pixels of each line plus the flyback margin. Every strobe comes from a counter whose period is one line or a multiple of one line. The default line is 303 clocks, which is 6 MHz divided by 60 frames and then by 329 lines, using integer division. The default frame is 329 lines: 320 visible and 9 blanking.

The counters do not start together. When `en` rises, the reversal counter starts first. The latch counter starts once the reversal count has passed 11. The line start, window and frame counters start together, with `running_o` rising, once the latch count reaches 3. Dropping `en` stops everything at once. Every strobe goes to its inactive level. The next enable replays the whole start sequence. There is no data path, so the block has no handshake.

Top module: `lcd_strobe_gen`

## Requirements
- R1: While reset is held or `en` is low, `rev_o`, `latch_o`, `frame_o`, `lstart_o` and `running_o` are 0 and `win_n_o` is 1.
- R2: Counting t=0 as the first cycle after the clock edge that samples `en` high, `rev_o` is 1 when (t mod 2*LINE_CLKS) < LINE_CLKS and 0 otherwise.
- R3: The latch counter starts on the edge after the reversal count first exceeds 11, so `latch_o` is 1 exactly when t >= 13 and (t-13) mod LINE_CLKS = 0.
- R4: The group counters start on the edge after the latch count equals 3. `running_o` is 0 for t < 17 and 1 from t = 17 on.
- R5: With g = t-17, `lstart_o` is 1 for exactly one clock, when g >= 0 and g mod LINE_CLKS = 0.
- R6: `win_n_o` is 0 (active) when g >= 0 and (g mod LINE_CLKS) < WIN_CLKS (default 248), and 1 otherwise.
- R7: `frame_o` is 1 when g >= 0 and (g mod (LINE_CLKS*FRAME_LINES)) < 2*LINE_CLKS, so it repeats once per frame.
- R8: When `en` is sampled low, including partway through the start sequence, all outputs return to the R1 state on that edge. A later enable restarts from t = 0 with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request; low stops all strobes |
| rev_o | output | 1 | Polarity reversal, toggles every line |
| latch_o | output | 1 | One-clock line latch pulse |
| frame_o | output | 1 | Frame start pulse, two lines wide |
| lstart_o | output | 1 | One-clock line start pulse |
| win_n_o | output | 1 | Active-low per-line enable window |
| running_o | output | 1 | High once all counters are running |

## Verification
The assertions check several properties on every cycle. A low `en` silences every strobe on the next cycle. Each line start falls inside the enable window. Each rising edge of the frame pulse coincides with a line start. The sequencer only moves forward through its stages. The group stage is entered only after the latch count hit its gate value. The reversal signal changes level only at line boundaries.

The exact start offsets (13 and 17 cycles) and the window and pulse widths are checked only by the bench's behavioural model. So are the frame repeating after a full 329-line frame and the restart after an abort partway through the start sequence.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REV  = 2'd1,
    ST_LAT  = 2'd2,
    ST_RUN  = 2'd3
  } lcdt_stage_e;
endpackage

// File: rtl/lcdt_cycle_ctr.sv
module lcdt_cycle_ctr #(
  parameter int PERIOD = 303,
  localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] TOP = W'(PERIOD - 1);

  assign last = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (step) begin
      if (last) cnt <= '0;
      else      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/lcdt_sequencer.sv
module lcdt_sequencer
  import lcdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rev_past_gate,
  input  logic lat_at_gate,
  output logic rev_run,
  output logic lat_run,
  output logic grp_run
);
  lcdt_stage_e st, st_nx;

  always_comb begin
    st_nx = st;
    if (!en) st_nx = ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE: st_nx = ST_REV;
        ST_REV:  if (rev_past_gate) st_nx = ST_LAT;
        ST_LAT:  if (lat_at_gate)   st_nx = ST_RUN;
        ST_RUN:  st_nx = ST_RUN;
        default: st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign rev_run = (st != ST_IDLE);
  assign lat_run = (st == ST_LAT) || (st == ST_RUN);
  assign grp_run = (st == ST_RUN);

  // R3
  lat_after_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LAT) |-> ($past(st) == ST_REV || $past(st) == ST_LAT));

  // R4
  grp_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && $past(st) != ST_RUN) |-> ($past(lat_at_gate) && $past(st) == ST_LAT));
endmodule

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen #(
  parameter int LINE_CLKS   = 303,
  parameter int FRAME_LINES = 329,
  parameter int WIN_CLKS    = 248,
  parameter int REV_GATE    = 11,
  parameter int LAT_GATE    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic rev_o,
  output logic latch_o,
  output logic frame_o,
  output logic lstart_o,
  output logic win_n_o,
  output logic running_o
);
  localparam int REV_PER = 2 * LINE_CLKS;
  localparam int RW = (REV_PER > 2) ? $clog2(REV_PER) : 1;
  localparam int LW = (LINE_CLKS > 2) ? $clog2(LINE_CLKS) : 1;
  localparam int FW = (FRAME_LINES > 2) ? $clog2(FRAME_LINES) : 1;
  localparam logic [RW-1:0] REV_GATE_C = RW'(REV_GATE);
  localparam logic [RW-1:0] REV_HALF_C = RW'(LINE_CLKS);
  localparam logic [LW-1:0] LAT_GATE_C = LW'(LAT_GATE);
  localparam logic [LW-1:0] WIN_C      = LW'(WIN_CLKS);
  localparam logic [FW-1:0] FRM_W_C    = FW'(2);

  logic rev_run, lat_run, grp_run;
  logic [RW-1:0] rev_cnt;
  logic [LW-1:0] lat_cnt, ln_cnt;
  logic [FW-1:0] lidx;
  logic rev_last, lat_last, ln_last, lidx_last;

  lcdt_sequencer u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .rev_past_gate (rev_cnt > REV_GATE_C),
    .lat_at_gate   (lat_cnt == LAT_GATE_C),
    .rev_run       (rev_run),
    .lat_run       (lat_run),
    .grp_run       (grp_run)
  );

  lcdt_cycle_ctr #(.PERIOD(REV_PER)) u_rev_ctr (
    .clk(clk), .rst_n(rst_n), .run(rev_run), .step(1'b1),
    .cnt(rev_cnt), .last(rev_last));

  lcdt_cycle_ctr #(.PERIOD(LINE_CLKS)) u_lat_ctr (
    .clk(clk), .rst_n(rst_n), .run(lat_run), .step(1'b1),
    .cnt(lat_cnt), .last(lat_last));

  lcdt_cycle_ctr #(.PERIOD(LINE_CLKS)) u_line_ctr (
    .clk(clk), .rst_n(rst_n), .run(grp_run), .step(1'b1),
    .cnt(ln_cnt), .last(ln_last));

  lcdt_cycle_ctr #(.PERIOD(FRAME_LINES)) u_frame_ctr (
    .clk(clk), .rst_n(rst_n), .run(grp_run), .step(ln_last),
    .cnt(lidx), .last(lidx_last));

  assign rev_o     = rev_run && (rev_cnt < REV_HALF_C);
  assign latch_o   = lat_run && (lat_cnt == '0);
  assign lstart_o  = grp_run && (ln_cnt == '0);
  assign win_n_o   = !(grp_run && (ln_cnt < WIN_C));
  assign frame_o   = grp_run && (lidx < FRM_W_C);
  assign running_o = grp_run;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rev_o && !latch_o && !frame_o && !lstart_o && win_n_o && !running_o));

  // R5
  start_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lstart_o |-> !win_n_o);

  // R7
  frame_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> lstart_o);

  // R2
  rev_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rev_run) && rev_run && rev_o != $past(rev_o)) |-> (rev_cnt == '0 || rev_cnt == REV_HALF_C));
endmodule

// File: tb/lcd_strobe_gen_test.sv
module lcd_strobe_gen_test;
  localparam int L = 303;
  localparam int F = 329;
  localparam int WIN = 248;
  localparam int T_LAT = 13;
  localparam int T_GRP = 17;

  logic clk = 0;
  logic rst_n = 0;
  logic en = 0;
  logic rev_o, latch_o, frame_o, lstart_o, win_n_o, running_o;

  int checks = 0;
  int errors = 0;
  int t = -1;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .rev_o(rev_o), .latch_o(latch_o), .frame_o(frame_o),
    .lstart_o(lstart_o), .win_n_o(win_n_o), .running_o(running_o));

  // Behavioural model: cycles since enable was sampled high
  always @(posedge clk) begin
    if (!rst_n || !en) t = -1;
    else               t = t + 1;
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s t=%0d actual=%b expected=%b", req, nm, t, act, exp);
    end
  endtask

  task automatic compare_all();
    int g;
    logic e_rev, e_lat, e_run, e_ls, e_wn, e_fr;
    g = t - T_GRP;
    e_rev = (t >= 0) && ((t % (2*L)) < L);
    e_lat = (t >= T_LAT) && (((t - T_LAT) % L) == 0);
    e_run = (g >= 0);
    e_ls  = e_run && ((g % L) == 0);
    e_wn  = !(e_run && ((g % L) < WIN));
    e_fr  = e_run && ((g % (L*F)) < 2*L);
    chk("R2", "rev_o", rev_o, e_rev);
    chk("R3", "latch_o", latch_o, e_lat);
    chk("R4", "running_o", running_o, e_run);
    chk("R5", "lstart_o", lstart_o, e_ls);
    chk("R6", "win_n_o", win_n_o, e_wn);
    chk("R7", "frame_o", frame_o, e_fr);
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, "rev_o idle", rev_o, 1'b0);
    chk(req, "latch_o idle", latch_o, 1'b0);
    chk(req, "frame_o idle", frame_o, 1'b0);
    chk(req, "lstart_o idle", lstart_o, 1'b0);
    chk(req, "win_n_o idle", win_n_o, 1'b1);
    chk(req, "running_o idle", running_o, 1'b0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_idle("R1");

    // Full frame plus the next frame pulse: R2..R7
    en = 1;
    run_cycles(L*F + 3*L);

    // R8: disable during steady running
    en = 0;
    @(negedge clk);
    check_idle("R8");
    run_cycles(5);

    // R8: abort partway through the start sequence, then restart
    en = 1;
    run_cycles(15);
    en = 0;
    @(negedge clk);
    check_idle("R8");
    en = 1;
    run_cycles(3*L);

    // R1: reset during running
    rst_n = 0;
    @(negedge clk);
    check_idle("R1");
    rst_n = 1;
    run_cycles(2*L);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule